// File: doc/BRIEF.md
# Byte-Wide Static Memory with Single-Error Correction

This block is a byte-wide static memory that protects every stored byte with a single-error-correcting Hamming code. Each byte is written together with four check bits, forming a 12-bit codeword. On a read, a syndrome is computed from the stored codeword. A single flipped bit, whether in the data or in a check bit, is repaired on its way to the output, and an error flag is raised at the same time. The repaired word is never written back, so the fault stays in the array until that address is written again.

The interface follows the usual asynchronous-memory control set, but every access is sampled on a clock edge. It has an active-low select, an active-low write strobe, an active-low output strobe, an address bus and a byte data path. The data path is split into an input byte, an output byte and an output-drive enable that a pad ring turns into a tri-state bus. A test-only port XORs a 12-bit mask into the stored codeword at the presented address, so single-bit faults can be planted and observed.

The address width is a parameter, and the depth is derived from it. A full-size build uses a 19-bit address (512K words). The default is kept small so that the default build elaborates quickly.

Top module: `ecc_sram`

## Requirements
- R1: On a rising clock edge with `cs_n`=0 and `we_n`=0, the byte on `din` is encoded and stored at `addr`.
- R2: On a rising clock edge with `cs_n`=0, `oe_n`=0 and `we_n`=1, the corrected byte stored at `addr` appears on `dout`, and `dout_oe` is 1 from that edge until the next one (one-cycle read latency).
- R3: After any edge at which `cs_n`=1 or `oe_n`=1, `dout_oe` is 0 (outputs high-impedance) until the next edge.
- R4: If `cs_n`=0 and both `we_n` and `oe_n` are 0, the write takes effect and `dout_oe` stays 0.
- R5: The codeword holds bit positions 1..12 (mask bit i is position i+1). Check bits sit at positions 1, 2, 4 and 8. Data bits 0..7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. A single flipped data position is corrected on read, and `err` is 1 with that read.
- R6: A single flipped check-bit position (1, 2, 4 or 8) leaves the read byte unchanged, and `err` is 1 with that read.
- R7: A correction is never written back: reading a faulty address again still returns corrected data with `err`=1.
- R8: `err` is 0 whenever `dout_oe` is 0, and is 0 on a read of a codeword whose syndrome is zero.
- R9: A new write to an address stores fresh check bits, so a later read of it has `err`=0.
- R10: On a rising edge with `inj_en`=1 and no write, `inj_mask` is XORed into the stored codeword at `addr`. When a write occurs on the same edge, the write wins and the mask is dropped.
- R11: While `rst_n`=0, `dout_oe`, `err` and `dout` are 0. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Write data byte |
| dout | output | 8 | Corrected read data byte |
| dout_oe | output | 1 | Output-drive enable for the data pads (0 = high-impedance) |
| err | output | 1 | Error flag, valid together with read data |
| inj_en | input | 1 | Test-only: apply fault mask at this edge |
| inj_mask | input | 12 | Test-only: mask XORed into the stored codeword |

## Verification
Writes, fault injections and reads are all sampled at a rising edge. The stored codeword changes at that edge, and `dout`, `dout_oe` and `err` settle just after it. Every operation therefore has exactly one result due one cycle later: the read byte and flag, or the high-impedance state for a write or an idle cycle. The driver applies each operation at a falling edge and queues its expected output. The monitor pops one entry per cycle, two nanoseconds after the following rising edge, so each comparison lands on the edge that produced it. Faults are planted and removed with the injection port between reads, so both the flagged and the clean read of the same address are checked at the ports.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [CHK_W-1:0]  syn_t;

  // position p (1-based) holds a check bit when p is a power of two
  function automatic logic is_chk_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // spread data over non-power-of-two positions, then fill check bits
  function automatic cw_t sec_encode(byte_t d);
    cw_t cw;
    int  k;
    logic par;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    for (int c = 0; c < CHK_W; c++) begin
      par = 1'b0;
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> c) & 1) == 1 && !is_chk_pos(p)) par = par ^ cw[p-1];
      end
      cw[(1 << c) - 1] = par;
    end
    return cw;
  endfunction

  // XOR of the positions of all set bits; zero for a clean word
  function automatic syn_t sec_syndrome(cw_t cw);
    syn_t s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (cw[p-1]) s = s ^ CHK_W'(p);
    end
    return s;
  endfunction

  function automatic logic sec_fixable(syn_t s);
    return (s != '0) && (int'(s) <= CW_W);
  endfunction

  function automatic cw_t sec_correct(cw_t cw, syn_t s);
    cw_t r;
    r = cw;
    if (sec_fixable(s)) r[int'(s) - 1] = ~r[int'(s) - 1];
    return r;
  endfunction

  function automatic byte_t sec_extract(cw_t cw);
    byte_t d;
    int    k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        d[k] = cw[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/ecc_sram_encoder.sv
module ecc_sram_encoder
  import ecc_sram_pkg::*;
(
  input  logic  rst_n,
  input  byte_t data_in,
  output cw_t   cw_out
);
  assign cw_out = sec_encode(data_in);

  // a freshly encoded word must decode with a zero syndrome
  always_comb begin
    if (rst_n) begin
      AST_ENC_CLEAN: assert (sec_syndrome(cw_out) == '0); // R1
    end
  end
endmodule

// File: rtl/ecc_sram_decoder.sv
module ecc_sram_decoder
  import ecc_sram_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_active,
  input  cw_t   cw_in,
  output byte_t data_out,
  output syn_t  syn,
  output logic  err_hit
);
  cw_t fixed_cw;

  assign syn      = sec_syndrome(cw_in);
  assign fixed_cw = sec_correct(cw_in, syn);
  assign data_out = sec_extract(fixed_cw);
  assign err_hit  = (syn != '0);

  // a correctable word must come out of the repair with a clean syndrome
  AST_FIX_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && sec_fixable(syn)) |-> (sec_syndrome(fixed_cw) == '0)); // R5
endmodule

// File: rtl/ecc_sram_array.sv
module ecc_sram_array
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  cw_t               wr_cw,
  input  logic              inj_en,
  input  cw_t               inj_mask,
  output cw_t               rd_cw
);
  cw_t mem [DEPTH];

  logic inj_go;
  assign inj_go = inj_en && !wr_en;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wr_cw;
    end else if (inj_go) begin
      mem[addr] <= mem[addr] ^ inj_mask;
    end
  end

  assign rd_cw = mem[addr];

  // with no write or injection, the word at a held address must not change
  AST_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inj_go) |=> ($stable(addr) -> $stable(rd_cw))); // R7

  // a write lands exactly, even with an injection requested on the same edge
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($stable(addr) -> (rd_cw == $past(wr_cw)))); // R10
endmodule

// File: rtl/ecc_sram.sv
module ecc_sram
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe,
  output logic              err,
  input  logic              inj_en,
  input  logic [11:0]       inj_mask
);
  // decoded access events, named for the assertions
  logic  wr_go;
  logic  rd_go;
  cw_t   enc_cw;
  cw_t   arr_cw;
  byte_t dec_data;
  syn_t  dec_syn;
  logic  dec_err;

  assign wr_go = !cs_n && !we_n;
  assign rd_go = !cs_n && !oe_n && we_n;

  ecc_sram_encoder u_enc (
    .rst_n   (rst_n),
    .data_in (din),
    .cw_out  (enc_cw)
  );

  ecc_sram_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_go),
    .wr_cw    (enc_cw),
    .inj_en   (inj_en),
    .inj_mask (inj_mask),
    .rd_cw    (arr_cw)
  );

  ecc_sram_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_active (rd_go),
    .cw_in     (arr_cw),
    .data_out  (dec_data),
    .syn       (dec_syn),
    .err_hit   (dec_err)
  );

  // registered output stage: data, drive enable and flag move together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
      err     <= 1'b0;
    end else if (rd_go) begin
      dout    <= dec_data;
      dout_oe <= 1'b1;
      err     <= dec_err;
    end else begin
      dout_oe <= 1'b0;
      err     <= 1'b0;
    end
  end

  AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!cs_n && !oe_n)); // R3

  AST_WRITE_KEEPS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_go) |-> !dout_oe); // R4

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> dout_oe); // R2

  AST_ERR_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> dout_oe); // R8

  AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && dec_syn == '0) |=> !err); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!dout_oe && !err && dout == '0)); // R11
endmodule

// File: tb/ecc_sram_bench.sv
module ecc_sram_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_oe;
  logic          err;
  logic          inj_en = 1'b0;
  logic [11:0]   inj_mask = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic       oe;
    logic [7:0] data;
    logic       er;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  ecc_sram #(.ADDR_W(AW)) u_ecc_sram (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .err(err),
    .inj_en(inj_en), .inj_mask(inj_mask)
  );

  // codeword mask bit index of data bit d (positions 3,5,6,7,9,10,11,12)
  function automatic int data_mask_bit(int d);
    case (d)
      0: return 2;  1: return 4;  2: return 5;  3: return 6;
      4: return 8;  5: return 9;  6: return 10; default: return 11;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one operation at a falling edge and queues its result
  task automatic op(logic c, logic w, logic o, int a, logic [7:0] d,
                    logic ie, logic [11:0] m,
                    logic e_oe, logic [7:0] e_d, logic e_er, string tag);
    exp_t e;
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; addr = AW'(a); din = d;
    inj_en = ie; inj_mask = m;
    e.oe = e_oe; e.data = e_d; e.er = e_er; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wr(int a, logic [7:0] d, string tag);
    op(1'b0, 1'b0, 1'b1, a, d, 1'b0, '0, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic rd(int a, logic [7:0] d, logic e_er, string tag);
    op(1'b0, 1'b1, 1'b0, a, 8'h00, 1'b0, '0, 1'b1, d, e_er, tag);
  endtask

  task automatic inj(int a, logic [11:0] m, string tag);
    op(1'b1, 1'b1, 1'b1, a, 8'h00, 1'b1, m, 1'b0, 8'h00, 1'b0, tag);
  endtask

  // monitor: one result per cycle, sampled shortly after the rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, {7'd0, dout_oe}, {7'd0, e.oe}, "dout_oe");
      check(e.tag, {7'd0, err}, {7'd0, e.er}, "err");
      if (e.oe) check(e.tag, dout, e.data, "dout");
    end
  end

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  localparam int TOP = (1 << AW) - 1;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R11: outputs quiet during reset
    check("R11", {6'd0, dout_oe, err}, 8'h00, "reset oe/err");
    check("R11", dout, 8'h00, "reset dout");
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R2: store and read back several patterns
    wr(0, 8'h5A, "R1");
    wr(1, 8'hC3, "R1");
    wr(2, 8'hFF, "R1");
    wr(TOP, 8'h81, "R1");
    rd(0, 8'h5A, 1'b0, "R2");
    rd(1, 8'hC3, 1'b0, "R2");
    rd(2, 8'hFF, 1'b0, "R2");
    rd(TOP, 8'h81, 1'b0, "R2");

    // R3: deselected or output strobe high -> high-impedance
    op(1'b1, 1'b1, 1'b0, 0, 8'h00, 1'b0, '0, 1'b0, 8'h00, 1'b0, "R3");
    op(1'b0, 1'b1, 1'b1, 0, 8'h00, 1'b0, '0, 1'b0, 8'h00, 1'b0, "R3");
    rd(0, 8'h5A, 1'b0, "R3");

    // R4: write with output strobe low -> write wins, no drive
    op(1'b0, 1'b0, 1'b0, 0, 8'h11, 1'b0, '0, 1'b0, 8'h00, 1'b0, "R4");
    rd(0, 8'h11, 1'b0, "R4");

    // R5, R7, R8: flip data bit 3 at address 1
    inj(1, 12'(1 << data_mask_bit(3)), "R10");
    rd(1, 8'hC3, 1'b1, "R5");
    rd(1, 8'hC3, 1'b1, "R7");
    rd(2, 8'hFF, 1'b0, "R8");

    // R6: flip check position 4 at address 2
    inj(2, 12'h008, "R10");
    rd(2, 8'hFF, 1'b1, "R6");

    // R5, R6, R10: every single position at the top address, then undo
    for (int p = 0; p < 12; p++) begin
      inj(TOP, 12'(1 << p), "R10");
      rd(TOP, 8'h81, 1'b1, (p == 0 || p == 1 || p == 3 || p == 7) ? "R6" : "R5");
      inj(TOP, 12'(1 << p), "R10");
      rd(TOP, 8'h81, 1'b0, "R8");
    end

    // R9: rewrite clears the planted fault
    wr(1, 8'hC3, "R9");
    rd(1, 8'hC3, 1'b0, "R9");

    // R10: write and injection on the same edge -> mask dropped
    op(1'b0, 1'b0, 1'b1, 2, 8'h42, 1'b1, 12'h010, 1'b0, 8'h00, 1'b0, "R10");
    rd(2, 8'h42, 1'b0, "R10");

    op(1'b1, 1'b1, 1'b1, 0, 8'h00, 1'b0, '0, 1'b0, 8'h00, 1'b0, "R3");
    repeat (3) @(posedge clk);
    #3;
    finish_test();
  end
endmodule